// File: doc/BRIEF.md
# Fractional-Ratio Clock Coincidence Controller

This block is the digital control section that sits around a clock-multiplying PLL. The input clock and the PLL output clock (CLK1) reach it as single-cycle edge strobes, sampled on a fast system clock. Two programmable dividers, each set by a 7-bit word, divide the input edges by the reference word plus two and the CLK1 edges by the feedback word plus two. These divided edges feed the phase comparator. Once locked, the output runs at the input rate times (feedback word + 2) / (reference word + 2).

The block reduces that fraction to lowest terms with a small sequential gcd engine. It then tracks the phase of both clocks with two wrap counters, so it can flag every common rising edge with a one-CLK1-cycle sync pulse. The second output carries either that sync pulse or CLK1 divided by two. Separate enables control whether each clock output drives, under an output-enable input for the second clock and an active-low power-down input for both. A rate monitor flags divider settings that put the comparison rate outside 300 kHz to 20 MHz.

Top module: `frac_sync_ctrl`

## Requirements
- R1: `ref_div_edge` is high for one cycle, one cycle after the 1st, (R+3)th, (2R+5)th... `ref_tick` counted since the last restart (divide by reference word R plus 2).
- R2: `fb_div_edge` behaves the same way for `out_tick`, with divide ratio feedback word F plus 2.
- R3: With `div2_sel`=0, `clk2_out` rises in the cycle after a cycle where `ref_tick` and `out_tick` are both high (a common edge). It falls in the cycle after the next `out_tick` that is not a common edge, so it stays high for one CLK1 period.
- R4: A restart clears the sync pulse and holds it low until the first common edge after the ratio reduction finishes. A restart is a change of either word, or `pwrdn_n` low.
- R5: With `div2_sel`=1, `clk2_out` toggles one cycle after each `out_tick`. It is 0 while `pwrdn_n` is low, so the first CLK1 edge after power-up drives it high.
- R6: `clk2_en`=0 drives `clk2_drive_en` low one cycle later, while `clk1_drive_en` keeps following `pwrdn_n`.
- R7: `pwrdn_n`=0 drives both `clk1_drive_en` and `clk2_drive_en` low one cycle later and resets both dividers. After reset, every output is 0.
- R8: `cfg_err` compares P, the spacing in system cycles between successive `ref_div_edge` pulses, with SYS_KHZ/20000 and SYS_KHZ/300. It is set when P is below the first or above the second: 10 and 666 at the default 200 MHz. It is evaluated at each divided edge from the second one after a restart, and set as soon as the spacing passes the upper limit. A restart clears it.
- R9: The sync counters wrap at (R+2)/g input edges and (F+2)/g CLK1 edges, where g = gcd(R+2, F+2). Sync therefore marks every common edge of a stimulus at exactly that ratio, and no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per input clock rising edge |
| out_tick | input | 1 | One-cycle strobe per CLK1 rising edge |
| ref_word | input | 7 | Reference divider word R (ratio R+2) |
| fb_word | input | 7 | Feedback divider word F (ratio F+2) |
| div2_sel | input | 1 | 1: second output is CLK1/2; 0: sync pulse |
| clk2_en | input | 1 | Second output enable |
| pwrdn_n | input | 1 | Active-low power down |
| ref_div_edge | output | 1 | Divided reference edge strobe |
| fb_div_edge | output | 1 | Divided feedback edge strobe |
| clk2_out | output | 1 | Second clock output level |
| clk1_drive_en | output | 1 | CLK1 driver enable (low = tri-state) |
| clk2_drive_en | output | 1 | Second clock driver enable (low = tri-state) |
| cfg_err | output | 1 | Comparison rate out of range |

## Verification
The divider and sync checks run over word pairs of several kinds: a coprime pair, pairs whose gcd is greater than one and shrinks both wrap counts, equal words where every edge is common, and random pairs. Together they separate a correct fraction reduction from counters that wrap at the raw ratios. Each pair is driven with edge strobes spaced at exactly the programmed ratio, so common edges fall at known cycles. A second pattern drives random CLK1 strobes with a power-down pulse in the middle, which shows whether the divide-by-two output restarts from zero. Three directed settings sit at and around the rate limits: a comparison period of exactly 10 cycles, 9 cycles, and 992 cycles. They test whether each edge of the range check is inclusive and whether the timeout path fires.

// File: rtl/frac_sync_pkg.sv
// Shared types for the fractional-ratio coincidence controller.
package frac_sync_pkg;

    // Phases of the sequential ratio reduction engine.
    typedef enum logic [1:0] {
        RS_LOAD   = 2'd0,
        RS_EUCLID = 2'd1,
        RS_QUOT   = 2'd2,
        RS_DONE   = 2'd3
    } red_state_e;

endpackage

// File: rtl/ratio_reducer.sv
// Reduces (ref_word+2)/(fb_word+2) to lowest terms over several cycles.
// It takes g = gcd by subtractive Euclid, then each quotient by repeated
// subtraction of g. Assumes the words stay stable until ready rises; any
// change must come with restart, which reloads the engine.
module ratio_reducer
    import frac_sync_pkg::*;
#(
    parameter int WORD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [WORD_W-1:0] ref_word,
    input  logic [WORD_W-1:0] fb_word,
    output logic              ready,
    output logic [WORD_W:0]   ref_wrap,
    output logic [WORD_W:0]   fb_wrap
);
    localparam int RW = WORD_W + 1;
    localparam int PW = 2 * RW;

    red_state_e    st;
    logic [RW-1:0] a_q, b_q, g_q, ra_q, rb_q, qa_q, qb_q, aw_q, bw_q;
    logic [RW-1:0] ref_n, fb_n;

    assign ref_n = {1'b0, ref_word} + RW'(2);
    assign fb_n  = {1'b0, fb_word} + RW'(2);

    // Sequencer: load, find gcd, divide both ratios by it, hold result.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            st   <= RS_LOAD;
            a_q  <= '0;
            b_q  <= '0;
            g_q  <= '0;
            ra_q <= '0;
            rb_q <= '0;
            qa_q <= '0;
            qb_q <= '0;
            aw_q <= '0;
            bw_q <= '0;
        end else begin
            case (st)
                RS_LOAD: begin
                    a_q  <= ref_n;
                    b_q  <= fb_n;
                    ra_q <= ref_n;
                    rb_q <= fb_n;
                    aw_q <= ref_n;
                    bw_q <= fb_n;
                    qa_q <= '0;
                    qb_q <= '0;
                    st   <= RS_EUCLID;
                end
                RS_EUCLID: begin
                    if (a_q == b_q) begin
                        g_q <= a_q;
                        st  <= RS_QUOT;
                    end else if (a_q > b_q) begin
                        a_q <= a_q - b_q;
                    end else begin
                        b_q <= b_q - a_q;
                    end
                end
                RS_QUOT: begin
                    if (ra_q >= g_q) begin
                        ra_q <= ra_q - g_q;
                        qa_q <= qa_q + RW'(1);
                    end
                    if (rb_q >= g_q) begin
                        rb_q <= rb_q - g_q;
                        qb_q <= qb_q + RW'(1);
                    end
                    if (ra_q < g_q && rb_q < g_q) begin
                        st <= RS_DONE;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign ready    = (st == RS_DONE);
    assign ref_wrap = qa_q;
    assign fb_wrap  = qb_q;

    // R9: reduced wrap counts times the gcd give back the loaded ratios.
    a_r9_wrap_exact: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ((PW'(qa_q) * PW'(g_q) == PW'(aw_q)) &&
                   (PW'(qb_q) * PW'(g_q) == PW'(bw_q))));

    // R4: a restart always withdraws the reduced result.
    a_r4_restart_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !ready);

endmodule

// File: rtl/tick_divider.sv
// Divides a stream of edge strobes by word+2. It emits a one-cycle edge
// strobe on the cycle after the first strobe of each group. Assumes a tick
// is a single-cycle pulse; restart returns the count to the group start.
module tick_divider #(
    parameter int WORD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic [WORD_W-1:0] word,
    output logic              edge_o
);
    localparam int RW = WORD_W + 1;

    logic [RW-1:0] n_div;
    logic [RW-1:0] cnt_q;

    assign n_div = {1'b0, word} + RW'(2);

    // Count strobes modulo the ratio; flag the group-start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q  <= '0;
            edge_o <= 1'b0;
        end else if (tick) begin
            edge_o <= (cnt_q == '0);
            cnt_q  <= (cnt_q >= n_div - RW'(1)) ? '0 : cnt_q + RW'(1);
        end else begin
            edge_o <= 1'b0;
        end
    end

    // R1 R2: a ratio of at least two never gives back-to-back edges.
    a_r1_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

    // R1 R2: every divided edge is caused by a strobe one cycle earlier.
    a_r1_r2_edge_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> $past(tick));

endmodule

// File: rtl/coincidence_tracker.sv
// Tracks the phase of both clocks with wrap counters at the reduced ratio
// and raises sync for one CLK1 period at each common rising edge. Assumes
// the edge strobes really keep the programmed ratio; it arms on the first
// common edge seen after the reducer reports ready.
module coincidence_tracker #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          ready,
    input  logic          ref_tick,
    input  logic          out_tick,
    input  logic [RW-1:0] ref_wrap,
    input  logic [RW-1:0] fb_wrap,
    output logic          sync_o
);
    logic          armed_q;
    logic [RW-1:0] ca_q, cb_q;
    logic          both;
    logic [RW-1:0] ca_base, cb_base;

    // Advance a phase counter by one edge, wrapping at lim.
    function automatic logic [RW-1:0] step(input logic [RW-1:0] v,
                                           input logic [RW-1:0] lim);
        return (v >= lim - RW'(1)) ? '0 : v + RW'(1);
    endfunction

    assign both    = ref_tick && out_tick;
    assign ca_base = armed_q ? ca_q : '0;
    assign cb_base = armed_q ? cb_q : '0;

    // Phase counters, arming and the sync pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !ready) begin
            armed_q <= 1'b0;
            ca_q    <= '0;
            cb_q    <= '0;
            sync_o  <= 1'b0;
        end else begin
            if (ref_tick && (armed_q || out_tick)) begin
                ca_q <= step(ca_base, ref_wrap);
            end
            if (out_tick && (armed_q || ref_tick)) begin
                cb_q <= step(cb_base, fb_wrap);
            end
            if (both) begin
                armed_q <= 1'b1;
            end
            if (both && (!armed_q || (ca_q == '0 && cb_q == '0))) begin
                sync_o <= 1'b1;
            end else if (out_tick) begin
                sync_o <= 1'b0;
            end
        end
    end

    // R3: sync only rises after a cycle holding a common edge.
    a_r3_rise_on_common_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(both));

    // R3: sync only falls on a CLK1 edge or a restart.
    a_r3_fall_on_clk1_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> $past(out_tick || restart || !ready));

    // R9: phase counters stay inside the reduced wrap counts.
    a_r9_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((ca_q < ref_wrap) && (cb_q < fb_wrap)));

    // R4: no sync while the ratio is not reduced.
    a_r4_quiet_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !sync_o);

endmodule

// File: rtl/rate_monitor.sv
// Measures the spacing of divided reference edges in system cycles and
// flags a comparison rate outside LO_KHZ..HI_KHZ. Assumes clk runs at
// SYS_KHZ; the spacing counter saturates just above the upper limit.
module rate_monitor #(
    parameter int SYS_KHZ = 200000,
    parameter int LO_KHZ  = 300,
    parameter int HI_KHZ  = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic div_edge,
    output logic err_o
);
    localparam int MINP = SYS_KHZ / HI_KHZ;
    localparam int MAXP = SYS_KHZ / LO_KHZ;
    localparam int CW   = $clog2(MAXP + 2);

    logic [CW-1:0] cnt_q;
    logic          seen_q;

    // Spacing measurement, range check and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
            err_o  <= 1'b0;
        end else if (div_edge) begin
            if (seen_q) begin
                err_o <= (cnt_q < CW'(MINP)) || (cnt_q > CW'(MAXP));
            end
            seen_q <= 1'b1;
            cnt_q  <= CW'(1);
        end else begin
            if (cnt_q <= CW'(MAXP)) begin
                cnt_q <= cnt_q + CW'(1);
            end
            if (seen_q && cnt_q > CW'(MAXP)) begin
                err_o <= 1'b1;
            end
        end
    end

    // R8: the flag rises only on a measured edge or an overlong gap.
    a_r8_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($past(div_edge) || ($past(cnt_q) > CW'(MAXP))));

    // R8: a restart clears the flag.
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !err_o);

endmodule

// File: rtl/out_control.sv
// Drives the second clock output (sync or CLK1/2) and both driver enables.
// Assumes out_tick marks CLK1 rising edges; the half-rate flop is held at
// zero through power down so that its first rise lines up with CLK1.
module out_control (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrdn_n,
    input  logic clk2_en,
    input  logic div2_sel,
    input  logic out_tick,
    input  logic sync_i,
    output logic clk2_out,
    output logic oe1_o,
    output logic oe2_o
);
    logic half_q;

    // Half-rate toggle on each CLK1 edge, cleared in power down.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwrdn_n) begin
            half_q <= 1'b0;
        end else if (out_tick) begin
            half_q <= ~half_q;
        end
    end

    // Registered driver enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe1_o <= 1'b0;
            oe2_o <= 1'b0;
        end else begin
            oe1_o <= pwrdn_n;
            oe2_o <= pwrdn_n && clk2_en;
        end
    end

    assign clk2_out = div2_sel ? half_q : sync_i;

    // R7: power down tri-states both outputs and clears the half-rate flop.
    a_r7_pd_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n |=> (!oe1_o && !oe2_o && !half_q));

    // R5: the half-rate flop moves only on a CLK1 edge or power down.
    a_r5_half_on_clk1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(half_q) |-> ($past(out_tick) || $past(!pwrdn_n)));

    // R6: disabling the second output tri-states it on the next cycle.
    a_r6_oe2_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !clk2_en |=> !oe2_o);

endmodule

// File: rtl/frac_sync_ctrl.sv
// Top of the fractional-ratio coincidence controller: two edge dividers,
// ratio reduction, common-edge sync, rate check and output control.
// Assumes both clocks arrive as single-cycle strobes on the system clock.
module frac_sync_ctrl #(
    parameter int WORD_W  = 7,
    parameter int SYS_KHZ = 200000,
    parameter int LO_KHZ  = 300,
    parameter int HI_KHZ  = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              out_tick,
    input  logic [WORD_W-1:0] ref_word,
    input  logic [WORD_W-1:0] fb_word,
    input  logic              div2_sel,
    input  logic              clk2_en,
    input  logic              pwrdn_n,
    output logic              ref_div_edge,
    output logic              fb_div_edge,
    output logic              clk2_out,
    output logic              clk1_drive_en,
    output logic              clk2_drive_en,
    output logic              cfg_err
);
    localparam int RW   = WORD_W + 1;
    localparam int NDIV = 2;

    logic [WORD_W-1:0] ref_q, fb_q;
    logic              restart;
    logic              ready;
    logic [RW-1:0]     ref_wrap, fb_wrap;
    logic              sync;
    logic [NDIV-1:0]   tick_v;
    logic [NDIV-1:0]   edge_v;
    logic [WORD_W-1:0] word_v [NDIV];

    // Word history for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
            fb_q  <= '0;
        end else begin
            ref_q <= ref_word;
            fb_q  <= fb_word;
        end
    end

    assign restart   = !pwrdn_n || (ref_word != ref_q) || (fb_word != fb_q);
    assign tick_v    = {out_tick, ref_tick};
    assign word_v[0] = ref_word;
    assign word_v[1] = fb_word;

    generate
        for (genvar i = 0; i < NDIV; i++) begin : g_div
            tick_divider #(.WORD_W(WORD_W)) u_div (
                .clk    (clk),
                .rst_n  (rst_n),
                .restart(restart),
                .tick   (tick_v[i]),
                .word   (word_v[i]),
                .edge_o (edge_v[i])
            );
        end
    endgenerate

    assign ref_div_edge = edge_v[0];
    assign fb_div_edge  = edge_v[1];

    ratio_reducer #(.WORD_W(WORD_W)) u_red (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .ref_word(ref_word),
        .fb_word (fb_word),
        .ready   (ready),
        .ref_wrap(ref_wrap),
        .fb_wrap (fb_wrap)
    );

    coincidence_tracker #(.RW(RW)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .ready   (ready),
        .ref_tick(ref_tick),
        .out_tick(out_tick),
        .ref_wrap(ref_wrap),
        .fb_wrap (fb_wrap),
        .sync_o  (sync)
    );

    rate_monitor #(.SYS_KHZ(SYS_KHZ), .LO_KHZ(LO_KHZ), .HI_KHZ(HI_KHZ)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div_edge(edge_v[0]),
        .err_o   (cfg_err)
    );

    out_control u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwrdn_n (pwrdn_n),
        .clk2_en (clk2_en),
        .div2_sel(div2_sel),
        .out_tick(out_tick),
        .sync_i  (sync),
        .clk2_out(clk2_out),
        .oe1_o   (clk1_drive_en),
        .oe2_o   (clk2_drive_en)
    );

endmodule

// File: tb/tb_frac_sync_ctrl.sv
module tb_frac_sync_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       out_tick = 1'b0;
    logic [6:0] ref_word = '0;
    logic [6:0] fb_word = '0;
    logic       div2_sel = 1'b0;
    logic       clk2_en = 1'b1;
    logic       pwrdn_n = 1'b0;
    logic       ref_div_edge, fb_div_edge, clk2_out;
    logic       clk1_drive_en, clk2_drive_en, cfg_err;

    int total = 0;
    int bad   = 0;

    // Bench model state, updated from the spec at each rising edge.
    int cur_r = 0, cur_f = 0;
    int m_rc = 0, m_fc = 0;
    bit m_ref_edge = 0, m_fb_edge = 0, m_sync = 0, m_half = 0;
    bit sync_chk = 0;

    frac_sync_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .out_tick(out_tick),
        .ref_word(ref_word), .fb_word(fb_word), .div2_sel(div2_sel),
        .clk2_en(clk2_en), .pwrdn_n(pwrdn_n), .ref_div_edge(ref_div_edge),
        .fb_div_edge(fb_div_edge), .clk2_out(clk2_out),
        .clk1_drive_en(clk1_drive_en), .clk2_drive_en(clk2_drive_en),
        .cfg_err(cfg_err)
    );

    always #2.5 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R3 watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int gcd_f(input int a, input int b);
        while (a != b) begin
            if (a > b) a -= b;
            else b -= a;
        end
        return a;
    endfunction

    // One system cycle: drive strobes, update the model at the edge, check after it.
    task automatic cycle(input bit rt, input bit ot);
        ref_tick = rt;
        out_tick = ot;
        @(posedge clk);
        if (!pwrdn_n) begin
            m_rc = 0; m_fc = 0;
            m_ref_edge = 0; m_fb_edge = 0; m_sync = 0; m_half = 0;
        end else begin
            m_ref_edge = rt && (m_rc == 0);
            if (rt) m_rc = (m_rc + 1) % (cur_r + 2);
            m_fb_edge = ot && (m_fc == 0);
            if (ot) m_fc = (m_fc + 1) % (cur_f + 2);
            if (rt && ot) m_sync = 1;
            else if (ot) m_sync = 0;
            if (ot) m_half = !m_half;
        end
        @(negedge clk);
        chk("R1 ref divided edge", ref_div_edge, m_ref_edge);
        chk("R2 fb divided edge", fb_div_edge, m_fb_edge);
        if (!div2_sel && !pwrdn_n) chk("R4 sync low in power down", clk2_out, 0);
        if (!div2_sel && sync_chk) chk("R3 R9 sync pulse", clk2_out, m_sync);
        if (div2_sel) chk("R5 half-rate output", clk2_out, m_half);
    endtask

    // Program a word pair, then run strobes at exactly the programmed ratio.
    task automatic run_case(input int r, input int f);
        int g, tin, tout, win, per;
        bit exp_err;
        sync_chk = 0;
        pwrdn_n = 0;
        ref_word = 7'(r);
        fb_word = 7'(f);
        cur_r = r;
        cur_f = f;
        repeat (3) cycle(0, 0);
        chk("R7 clk1 off in power down", clk1_drive_en, 0);
        chk("R7 clk2 off in power down", clk2_drive_en, 0);
        pwrdn_n = 1;
        g = gcd_f(r + 2, f + 2);
        tin = (f + 2) / g;
        tout = (r + 2) / g;
        per = tin * (r + 2);
        win = 300 + 2 * tin * tout + 2 * per;
        for (int c = 0; c < win; c++) begin
            bit rt = (c % tin) == 0;
            bit ot = (c % tout) == 0;
            if (rt && ot && c >= 300) sync_chk = 1;
            cycle(rt, ot);
        end
        exp_err = (per < 10) || (per > 666);
        chk($sformatf("R8 cfg_err r=%0d f=%0d period=%0d", r, f, per), cfg_err, int'(exp_err));
        chk("R7 clk1 driving when powered", clk1_drive_en, 1);
        sync_chk = 0;
    endtask

    initial begin
        void'($urandom(32'd5171));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        chk("R7 reset clk1_drive_en", clk1_drive_en, 0);
        chk("R7 reset clk2_drive_en", clk2_drive_en, 0);
        chk("R1 reset ref edge", ref_div_edge, 0);
        chk("R8 reset cfg_err", cfg_err, 0);
        chk("R3 reset clk2_out", clk2_out, 0);
        rst_n = 1;

        // Directed pairs: coprime, shared factor, equal, rate boundaries.
        run_case(2, 3);    // period 20, in range
        run_case(0, 0);    // every edge common, period 2: R8 error
        run_case(3, 0);    // period exactly 10: R8 in range
        run_case(7, 1);    // period 9: R8 error
        run_case(4, 10);   // gcd 6 reduces both wraps (R9)
        run_case(30, 29);  // period 992: R8 timeout
        for (int k = 0; k < 6; k++) begin
            run_case(int'($urandom % 13), int'($urandom % 13));
        end

        // R6: second output enable alone.
        clk2_en = 0;
        cycle(0, 0);
        chk("R6 clk2 tri-stated", clk2_drive_en, 0);
        chk("R6 clk1 unaffected", clk1_drive_en, 1);
        clk2_en = 1;
        cycle(0, 0);
        chk("R6 clk2 re-enabled", clk2_drive_en, 1);

        // R5: divide-by-two output with random CLK1 edges and a power-down pulse.
        pwrdn_n = 0;
        div2_sel = 1;
        repeat (2) cycle(0, 0);
        pwrdn_n = 1;
        cycle(0, 1);
        chk("R5 first edge after power-up drives high", clk2_out, 1);
        for (int c = 0; c < 160; c++) begin
            pwrdn_n = !(c >= 70 && c < 73);
            cycle(0, 1'($urandom % 2));
        end
        pwrdn_n = 1;
        div2_sel = 0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule